// File: doc/BRIEF.md
# Mirrored Memory Region Address Decoder

This block sits between a 32-bit processor load/store port and the memories and devices behind it. Each request carries an address, an access size, a read/write flag and the processor's cache-isolate status bit. The decoder ignores the three segment bits at the top of the address and looks up the 13-bit page number in bits 28:16. From that it selects exactly one target, or none for an unmapped access. It also forms the offset local to that target and a write enable that is qualified per target.

Main RAM is aliased several times across a wider window. The hardware-register page is split further on address bits 15:12. The two ROM regions accept writes only by swallowing them. While the isolate bit is set, no write reaches RAM-backed storage. Each write that does reach RAM-backed storage also produces a one-cycle invalidate pulse with the word-aligned address, so that an instruction cache can discard a stale line. All results appear one clock after the request. The select and the offset hold their values while no request is present.

Top module: `mem_region_decoder`

## Requirements
- R1: Address bits 31:29 have no effect on any output except `inval_addr_o`, where they always read as zero.
- R2: Pages 0x0000 to 0x007F select main RAM (select bit 0), offset = {page[4:0], addr[15:0]}. A write sets write-enable bit 0.
- R3: Page 0x1F00 selects the parameter page (select bit 1), offset = addr[15:0]. Reads and writes are both allowed.
- R4: Page 0x1F80 is the hardware page. Bits 15:12 equal to 0x1, 0x3 or 0x8 select bit 2, 3 or 4 respectively, and any other value selects the register scratch array (bit 5). The offset is addr[15:0] and writes are enabled.
- R5: Pages 0x1FC0 to 0x1FFF select the main ROM (bit 7) with offset {page[5:0], addr[15:0]}. Pages 0x1E00 to 0x1E03 select the extension ROM (bit 8) with offset {page[1:0], addr[15:0]}. A write to either gets no write enable and no error.
- R6: Page 0x1D00 selects the mailbox block (bit 6) and page 0x1000 selects the expansion port (bit 9), for every access size, read or write, with offset addr[15:0].
- R7: Page 0x1F90 selects the sound port (bit 10) only for half-word accesses (size code 1). Page 0x1F40 selects the auxiliary port (bit 11) only for byte accesses (size code 0). Any other size on these pages is unmapped (word = 2; code 3 also counts as not byte and not half).
- R8: When `isolate` is 1, a write to RAM or to the parameter page selects nothing, enables no write, raises the error flag and gives no invalidate. Reads, and writes to device or mailbox pages, are unaffected.
- R9: An unmapped access drives the select to all zeros, the offset to zero and the write enable to zero, and raises `err_o` for one cycle.
- R10: Each enabled write to RAM or to the parameter page pulses `inval_o` for one cycle with `inval_addr_o` = {3'b000, addr[28:2], 2'b00}.
- R11: Outputs change exactly one clock after a request is sampled. Without a request, select and offset hold their values and `we_o`, `err_o`, `inval_o` are zero.
- R12: During reset, select, offset and write enable are zero and `err_o`, `inval_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word |
| req_addr | input | 32 | Processor address |
| isolate | input | 1 | Cache-isolate status bit |
| sel_o | output | 12 | One-hot target select |
| off_o | output | 22 | Offset local to the target |
| we_o | output | 12 | Per-target write enable |
| err_o | output | 1 | Unmapped or blocked access flag |
| inval_o | output | 1 | Instruction-cache invalidate pulse |
| inval_addr_o | output | 32 | Word-aligned address to invalidate |

## Verification
The bench builds the decoder with its default page map: a 32-page RAM image mirrored over 128 pages, a 64-page main ROM and a 4-page extension ROM. With that map all 8192 page numbers can be swept, each under both directions and both isolate settings, with the segment bits and the access size rotated from page to page. A second sweep covers every value of bits 15:12 on the hardware page and every size code, so every select bit, every rejected size and every mirror alias is exercised against arithmetic expectations.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

    typedef enum logic [3:0] {
        T_RAM      = 4'd0,
        T_PARAM    = 4'd1,
        T_HW_A     = 4'd2,
        T_HW_B     = 4'd3,
        T_HW_C     = 4'd4,
        T_HW_SCR   = 4'd5,
        T_MBOX     = 4'd6,
        T_ROM_MAIN = 4'd7,
        T_ROM_EXT  = 4'd8,
        T_EXP      = 4'd9,
        T_SND      = 4'd10,
        T_AUX      = 4'd11,
        T_NONE     = 4'd15
    } tgt_e;

    localparam int NUM_TGT = 12;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mrd_page_class.sv
module mrd_page_class
    import mrd_pkg::*;
#(
    parameter int PAGE_W        = 13,
    parameter int HI_W          = 6,
    parameter int RAM_WIN_PAGES = 128,
    parameter int RAM_LOG2      = 5,
    parameter int ROM_MAIN_BASE = 'h1FC0,
    parameter int ROM_MAIN_LOG2 = 6,
    parameter int ROM_EXT_BASE  = 'h1E00,
    parameter int ROM_EXT_LOG2  = 2,
    parameter int PARAM_PAGE    = 'h1F00,
    parameter int HW_PAGE       = 'h1F80,
    parameter int MBOX_PAGE     = 'h1D00,
    parameter int EXP_PAGE      = 'h1000,
    parameter int SND_PAGE      = 'h1F90,
    parameter int AUX_PAGE      = 'h1F40
) (
    input  logic [PAGE_W-1:0] page_i,
    output tgt_e              region_o,
    output logic [HI_W-1:0]   hi_o
);

    localparam int ROM_MAIN_END = ROM_MAIN_BASE + (1 << ROM_MAIN_LOG2);
    localparam int ROM_EXT_END  = ROM_EXT_BASE + (1 << ROM_EXT_LOG2);

    int pg;

    always_comb begin
        pg       = int'(page_i);
        region_o = T_NONE;
        hi_o     = '0;
        if (pg < RAM_WIN_PAGES) begin
            // the low page bits pick the image; upper window bits alias
            region_o = T_RAM;
            hi_o     = HI_W'(page_i[RAM_LOG2-1:0]);
        end else if (pg >= ROM_MAIN_BASE && pg < ROM_MAIN_END) begin
            region_o = T_ROM_MAIN;
            hi_o     = HI_W'(page_i[ROM_MAIN_LOG2-1:0]);
        end else if (pg >= ROM_EXT_BASE && pg < ROM_EXT_END) begin
            region_o = T_ROM_EXT;
            hi_o     = HI_W'(page_i[ROM_EXT_LOG2-1:0]);
        end else if (pg == PARAM_PAGE) begin
            region_o = T_PARAM;
        end else if (pg == HW_PAGE) begin
            region_o = T_HW_SCR;
        end else if (pg == MBOX_PAGE) begin
            region_o = T_MBOX;
        end else if (pg == EXP_PAGE) begin
            region_o = T_EXP;
        end else if (pg == SND_PAGE) begin
            region_o = T_SND;
        end else if (pg == AUX_PAGE) begin
            region_o = T_AUX;
        end
    end

endmodule

// File: rtl/mrd_hw_subsel.sv
module mrd_hw_subsel
    import mrd_pkg::*;
#(
    parameter logic [3:0] SUB_A = 4'h1,
    parameter logic [3:0] SUB_B = 4'h3,
    parameter logic [3:0] SUB_C = 4'h8
) (
    input  logic [3:0] nib_i,
    output tgt_e       sub_o
);

    always_comb begin
        if (nib_i == SUB_A)      sub_o = T_HW_A;
        else if (nib_i == SUB_B) sub_o = T_HW_B;
        else if (nib_i == SUB_C) sub_o = T_HW_C;
        else                     sub_o = T_HW_SCR;
    end

endmodule

// File: rtl/mrd_access_gate.sv
module mrd_access_gate
    import mrd_pkg::*;
(
    input  tgt_e       region_i,
    input  logic       wr_i,
    input  logic [1:0] size_i,
    input  logic       iso_i,
    output tgt_e       tgt_o,
    output logic       we_o,
    output logic       err_o,
    output logic       inval_o
);

    always_comb begin
        tgt_o   = region_i;
        we_o    = wr_i;
        err_o   = 1'b0;
        inval_o = 1'b0;
        unique case (region_i)
            T_RAM, T_PARAM: begin
                if (wr_i && iso_i) begin
                    tgt_o = T_NONE;
                    we_o  = 1'b0;
                    err_o = 1'b1;
                end else begin
                    inval_o = wr_i;
                end
            end
            T_ROM_MAIN, T_ROM_EXT: begin
                we_o = 1'b0;
            end
            T_SND: begin
                if (size_i != SZ_HALF) begin
                    tgt_o = T_NONE;
                    we_o  = 1'b0;
                    err_o = 1'b1;
                end
            end
            T_AUX: begin
                if (size_i != SZ_BYTE) begin
                    tgt_o = T_NONE;
                    we_o  = 1'b0;
                    err_o = 1'b1;
                end
            end
            T_NONE: begin
                we_o  = 1'b0;
                err_o = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mem_region_decoder.sv
module mem_region_decoder
    import mrd_pkg::*;
#(
    parameter int RAM_WIN_PAGES = 128,
    parameter int RAM_LOG2      = 5,
    parameter int ROM_MAIN_BASE = 'h1FC0,
    parameter int ROM_MAIN_LOG2 = 6,
    parameter int ROM_EXT_BASE  = 'h1E00,
    parameter int ROM_EXT_LOG2  = 2,
    parameter int PARAM_PAGE    = 'h1F00,
    parameter int HW_PAGE       = 'h1F80,
    parameter int MBOX_PAGE     = 'h1D00,
    parameter int EXP_PAGE      = 'h1000,
    parameter int SND_PAGE      = 'h1F90,
    parameter int AUX_PAGE      = 'h1F40,
    parameter int HI_W          = imax(RAM_LOG2, imax(ROM_MAIN_LOG2, ROM_EXT_LOG2)),
    parameter int OFF_W         = 16 + HI_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [1:0]         req_size,
    input  logic [31:0]        req_addr,
    input  logic               isolate,
    output logic [NUM_TGT-1:0] sel_o,
    output logic [OFF_W-1:0]   off_o,
    output logic [NUM_TGT-1:0] we_o,
    output logic               err_o,
    output logic               inval_o,
    output logic [31:0]        inval_addr_o
);

    localparam int PAGE_W = 13;

    typedef struct packed {
        logic [NUM_TGT-1:0] sel;
        logic [OFF_W-1:0]   off;
        logic [NUM_TGT-1:0] we;
        logic               err;
        logic               inval;
        logic [31:0]        inval_addr;
    } dec_st_t;

    dec_st_t st_d, st_q;

    logic [PAGE_W-1:0] page;
    tgt_e              region_raw, hw_sub, region, tgt;
    logic [HI_W-1:0]   hi;
    logic              g_we, g_err, g_inval;
    logic              unused_seg;

    // segment bits never reach the decode
    assign page       = req_addr[28:16];
    assign unused_seg = ^{req_addr[31:29], req_addr[1:0]};

    mrd_page_class #(
        .PAGE_W(PAGE_W), .HI_W(HI_W),
        .RAM_WIN_PAGES(RAM_WIN_PAGES), .RAM_LOG2(RAM_LOG2),
        .ROM_MAIN_BASE(ROM_MAIN_BASE), .ROM_MAIN_LOG2(ROM_MAIN_LOG2),
        .ROM_EXT_BASE(ROM_EXT_BASE), .ROM_EXT_LOG2(ROM_EXT_LOG2),
        .PARAM_PAGE(PARAM_PAGE), .HW_PAGE(HW_PAGE), .MBOX_PAGE(MBOX_PAGE),
        .EXP_PAGE(EXP_PAGE), .SND_PAGE(SND_PAGE), .AUX_PAGE(AUX_PAGE)
    ) u_class (
        .page_i   (page),
        .region_o (region_raw),
        .hi_o     (hi)
    );

    mrd_hw_subsel u_hwsub (
        .nib_i (req_addr[15:12]),
        .sub_o (hw_sub)
    );

    assign region = (region_raw == T_HW_SCR) ? hw_sub : region_raw;

    mrd_access_gate u_gate (
        .region_i (region),
        .wr_i     (req_write),
        .size_i   (req_size),
        .iso_i    (isolate),
        .tgt_o    (tgt),
        .we_o     (g_we),
        .err_o    (g_err),
        .inval_o  (g_inval)
    );

    always_comb begin
        st_d       = st_q;
        st_d.we    = '0;
        st_d.err   = 1'b0;
        st_d.inval = 1'b0;
        if (req_valid) begin
            if (tgt == T_NONE) begin
                st_d.sel = '0;
                st_d.off = '0;
            end else begin
                st_d.sel = NUM_TGT'(1) << tgt;
                st_d.off = {hi, req_addr[15:0]};
            end
            st_d.we         = g_we ? st_d.sel : '0;
            st_d.err        = g_err;
            st_d.inval      = g_inval;
            st_d.inval_addr = {3'b000, req_addr[28:2], 2'b00};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_o        = st_q.sel;
    assign off_o        = st_q.off;
    assign we_o         = st_q.we;
    assign err_o        = st_q.err;
    assign inval_o      = st_q.inval;
    assign inval_addr_o = st_q.inval_addr;

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_o)); // R2
    AST_ERR_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (sel_o == '0 && we_o == '0 && off_o == '0)); // R9
    AST_WE_WITHIN_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (we_o & ~sel_o) == '0); // R2
    AST_ROM_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o[T_ROM_MAIN] || sel_o[T_ROM_EXT]) |-> we_o == '0); // R5
    AST_ISO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_write && isolate) |-> (!we_o[T_RAM] && !we_o[T_PARAM] && !inval_o)); // R8
    AST_INVAL_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        inval_o |-> (inval_addr_o[1:0] == 2'b00 && inval_addr_o[31:29] == 3'b000
                     && (we_o[T_RAM] || we_o[T_PARAM]))); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> (we_o == '0 && !err_o && !inval_o)); // R11
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> ($stable(sel_o) && $stable(off_o))); // R11

endmodule

// File: tb/sim_mem_region_decoder.sv
module sim_mem_region_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_addr = '0;
    logic        isolate = 1'b0;
    logic [11:0] sel_o, we_o;
    logic [21:0] off_o;
    logic        err_o, inval_o;
    logic [31:0] inval_addr_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    mem_region_decoder u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .isolate(isolate),
        .sel_o(sel_o), .off_o(off_o), .we_o(we_o), .err_o(err_o),
        .inval_o(inval_o), .inval_addr_o(inval_addr_o)
    );

    function automatic int exp_tgt(input logic [31:0] a, input bit wr, input int sz, input bit iso);
        int p = int'(a[28:16]);
        int n = int'(a[15:12]);
        int t = -1;
        if (p < 128)                         t = 0;
        else if (p == 'h1F00)                t = 1;
        else if (p == 'h1F80)                t = (n == 1) ? 2 : (n == 3) ? 3 : (n == 8) ? 4 : 5;
        else if (p == 'h1D00)                t = 6;
        else if (p >= 'h1FC0)                t = 7;
        else if (p >= 'h1E00 && p <= 'h1E03) t = 8;
        else if (p == 'h1000)                t = 9;
        else if (p == 'h1F90 && sz == 1)     t = 10;
        else if (p == 'h1F40 && sz == 0)     t = 11;
        if (t >= 0 && t <= 1 && wr && iso)   t = -1;
        return t;
    endfunction

    function automatic string tag_of(input int t, input bit wr, input bit iso, input int p);
        if (t == 0) return "R2";
        if (t == 1) return "R3";
        if (t >= 2 && t <= 5) return "R4";
        if (t == 7 || t == 8) return "R5";
        if (t == 6 || t == 9) return "R6";
        if (t == 10 || t == 11) return "R7";
        if (wr && iso && (p < 128 || p == 'h1F00)) return "R8";
        if (p == 'h1F90 || p == 'h1F40) return "R7";
        return "R9";
    endfunction

    task automatic run_req(input logic [31:0] a, input bit wr, input int sz, input bit iso, input string force_tag);
        int t = exp_tgt(a, wr, sz, iso);
        int p = int'(a[28:16]);
        logic [11:0] esel, ewe;
        logic [21:0] eoff;
        bit eerr, einv;
        logic [31:0] eia;
        string tg;
        tg = (force_tag != "") ? force_tag : tag_of(t, wr, iso, p);
        if (t < 0) begin
            esel = '0; eoff = '0; eerr = 1'b1;
        end else begin
            esel = 12'(1) << t;
            eerr = 1'b0;
            if (t == 0)      eoff = 22'((p % 32) * 65536 + int'(a[15:0]));
            else if (t == 7) eoff = 22'((p - 'h1FC0) * 65536 + int'(a[15:0]));
            else if (t == 8) eoff = 22'((p - 'h1E00) * 65536 + int'(a[15:0]));
            else             eoff = 22'(a[15:0]);
        end
        ewe  = (t >= 0 && wr && t != 7 && t != 8) ? esel : '0;
        einv = (t == 0 || t == 1) && wr;
        eia  = {3'b000, a[28:2], 2'b00};
        req_valid = 1'b1; req_addr = a; req_write = wr; req_size = 2'(sz); isolate = iso;
        @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (sel_o !== esel || off_o !== eoff || we_o !== ewe || err_o !== eerr ||
            inval_o !== einv || (einv && inval_addr_o !== eia)) begin
            n_fail++;
            $display("FAIL %s addr=%h wr=%0d sz=%0d iso=%0d: sel=%h off=%h we=%h err=%0d inv=%0d ia=%h expected sel=%h off=%h we=%h err=%0d inv=%0d ia=%h",
                     tg, a, wr, sz, iso, sel_o, off_o, we_o, err_o, inval_o, inval_addr_o,
                     esel, eoff, ewe, eerr, einv, eia);
        end
    endtask

    task automatic chk(input string tg, input bit ok, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tg, act, expv);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: quiet outputs while reset is held
        chk("R12", sel_o == '0 && off_o == '0 && we_o == '0 && !err_o && !inval_o,
            {sel_o, off_o, we_o, err_o, inval_o}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: segment bits do not change the decode
        for (int s = 0; s < 8; s++)
            run_req({3'(s), 13'h0045, 16'hBEEF}, 1'b1, 2, 1'b0, "R1");
        // R10: invalidate address on mirrored RAM and parameter writes
        run_req(32'hA07F_1237, 1'b1, 0, 1'b0, "R10");
        run_req(32'h1F00_FFFE, 1'b1, 1, 1'b0, "R10");
        // R7: every size on the two size-restricted pages
        for (int z = 0; z < 4; z++) begin
            run_req(32'h1F90_0010, 1'b0, z, 1'b0, "R7");
            run_req(32'h1F40_0003, 1'b1, z, 1'b0, "R7");
        end

        // R11: hold select and offset while idle, pulses drop
        run_req(32'h0012_3456, 1'b1, 2, 1'b0, "R11");
        req_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R11", sel_o == 12'h001 && off_o == 22'h123456 && we_o == '0 && !err_o && !inval_o,
                {sel_o, off_o, we_o, err_o, inval_o}, {12'h001, 22'h123456, 12'h000, 2'b00});
        end
        // R11: an error pulse also lasts one cycle
        run_req(32'h0300_0000, 1'b0, 2, 1'b0, "R9");
        req_valid = 1'b0;
        @(negedge clk);
        chk("R11", !err_o && sel_o == '0, {err_o, sel_o}, '0);

        // R4: every sub-page nibble, size, direction and isolate value
        for (int nb = 0; nb < 16; nb++)
            for (int z = 0; z < 4; z++)
                for (int w = 0; w < 2; w++)
                    for (int iv = 0; iv < 2; iv++)
                        run_req({3'b100, 13'h1F80, 4'(nb), 12'h5A4}, w[0], z, iv[0], "");

        // full page sweep
        for (int p = 0; p < 8192; p++)
            for (int w = 0; w < 2; w++)
                for (int iv = 0; iv < 2; iv++) begin
                    logic [31:0] lo = 32'(p * 40503 + w * 7 + iv * 3);
                    run_req({3'(p) ^ 3'b101, 13'(p), lo[15:0]}, w[0], (p + w + iv) % 4, iv[0], "");
                end

        req_valid = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule